// File: doc/BRIEF.md
# Video Timing Sequencer

This block produces the horizontal and vertical timing of one video frame for a serial display link that carries parallel pixel video. It runs on the lane byte clock. Horizontal segments (sync, back porch, active payload, line total) are given in byte clock cycles, and vertical segments (sync, back porch, active, front porch) are given in lines. A frame is launched by the rising edge of the incoming vertical sync, once that input has been brought to active-high form by a per-signal polarity mask. The frame then runs to completion on its own, and the block waits for the next sync edge.

On every cycle of a frame the block reports the current horizontal and vertical phase, the cycle position within the line, the line index and a frame-start strobe. It also reports whether the link may drop to low power at that moment. That permission depends on the region, on a six-bit per-region enable and on the selected transmission mode (non-burst with sync pulses, non-burst with sync events, burst). All timing, mode and enable settings are captured in a shadow copy at frame start, so a frame is never built from mixed settings.

Top module: `vid_timing_seq`

## Requirements
- R1: After reset, `busy`, `frame_start`, `hpos`, `vline`, `hphase`, `vphase` and `ctl_norm` are all zero and `lp_ok` is one.
- R2: `ctl_norm` equals `ctl_in XOR cfg_pol`, registered once. Bit 0 is data-enable, bit 1 vertical sync, bit 2 horizontal sync, bit 3 shutdown and bit 4 colour mode; a polarity bit of one marks that input as active low.
- R3: While idle, a rising edge of `ctl_norm[1]` starts a frame one clock later. In the first frame cycle, `busy` and `frame_start` are high and `hpos`/`vline` are zero; `frame_start` is high in that cycle only.
- R4: Within a line, `hpos` counts up by one per clock. `hphase` is 0 (sync) for `hsa` cycles, then 1 (back porch) for `hbp`, then 2 (active) for `hact`, then 3 (front porch) for the rest. A segment of length zero does not appear.
- R5: A line lasts max(`hline`, `hsa+hbp+hact`) cycles, and at least one. The front porch is zero long when the first three segments overrun `hline`.
- R6: `vline` advances once per line. `vphase` uses the same 0..3 encoding for `vsa`, `vbp`, `vact` and `vfp` lines in that order. A frame has at least one line.
- R7: After the last cycle of the last line, `busy` drops, all positions return to zero, and the block stays idle until the next sync edge.
- R8: Rising edges of `ctl_norm[1]` while a frame is running are ignored.
- R9: Timing, mode and low-power enable inputs are sampled only at frame start. Changes made during a frame do not alter that frame. The polarity mask acts at once.
- R10: `lp_ok` is 1 when idle. During horizontal sync it is 0 for mode 0 (sync pulses) and for mode 3. For modes 1 and 2, sync is treated like back porch. On vertical blanking lines `lp_ok` takes enable bit 0 (sync), 1 (back porch) or 2 (front porch). On active lines it takes bit 4 in back porch and is 0 in the active segment. In front porch it takes bit 3 for mode 2 (burst) and bit 5 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsa | input | HW | Horizontal sync length, byte clocks |
| cfg_hbp | input | HW | Horizontal back porch length, byte clocks |
| cfg_hact | input | HW | Active payload length, byte clocks |
| cfg_hline | input | HW | Total line length, byte clocks |
| cfg_vsa | input | VW | Vertical sync lines |
| cfg_vbp | input | VW | Vertical back porch lines |
| cfg_vact | input | VW | Active lines |
| cfg_vfp | input | VW | Vertical front porch lines |
| cfg_mode | input | 2 | Transmission mode: 0 pulses, 1 events, 2 burst |
| cfg_lpen | input | 6 | Per-region low-power enables |
| cfg_pol | input | 5 | Active-low mask for the control inputs |
| ctl_in | input | 5 | Raw data-enable, vsync, hsync, shutdown, colour mode |
| ctl_norm | output | 5 | Registered active-high control inputs |
| busy | output | 1 | A frame is in progress |
| frame_start | output | 1 | First cycle of a frame |
| hpos | output | HW+2 | Cycle position within the line |
| hphase | output | 2 | Horizontal phase |
| vline | output | VW+2 | Line index within the frame |
| vphase | output | 2 | Vertical phase |
| lp_ok | output | 1 | Low-power return permitted |

## Verification
The bench builds the sequencer with HW=6 and VW=5. With those narrow fields, a vector whose sync, back porch and active lengths add up to more than the six-bit input range shows that the sums are carried in widened counters and not truncated. Each table vector is checked cycle by cycle through a whole frame. Along the way the bench rewrites the settings and re-pulses sync halfway through the frame, then confirms that the following frame picks up the new values. All four mode codes, an all-zero frame and an overrun line are included.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACTV  = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        VM_PULSE = 2'd0,
        VM_EVENT = 2'd1,
        VM_BURST = 2'd2,
        VM_RSVD  = 2'd3
    } vmode_e;

    // low-power enable bit positions
    localparam int LPB_VSYNC = 0;
    localparam int LPB_VBACK = 1;
    localparam int LPB_VFRNT = 2;
    localparam int LPB_VACTV = 3;
    localparam int LPB_HBACK = 4;
    localparam int LPB_HFRNT = 5;

    localparam int CTL_W  = 5;
    localparam int CTL_VS = 1;

    // position against three cumulative segment ends
    function automatic phase_e seg_of(input logic [31:0] pos,
                                      input logic [31:0] e_sync,
                                      input logic [31:0] e_back,
                                      input logic [31:0] e_actv);
        if (pos < e_sync)      return PH_SYNC;
        else if (pos < e_back) return PH_BACK;
        else if (pos < e_actv) return PH_ACTV;
        else                   return PH_FRONT;
    endfunction

endpackage

// File: rtl/vts_pol_sync.sv
module vts_pol_sync
    import vts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_in,
    input  logic [CTL_W-1:0] pol,
    input  logic             run,
    output logic [CTL_W-1:0] ctl_norm,
    output logic             start
);

    typedef struct packed {
        logic [CTL_W-1:0] norm;
        logic             vs_prev;
    } pol_st_t;

    pol_st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.norm    = ctl_in ^ pol;
        s_d.vs_prev = s_q.norm[CTL_VS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_norm = s_q.norm;
    assign start    = s_q.norm[CTL_VS] && !s_q.vs_prev && !run;

    AST_NORM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctl_norm == ($past(ctl_in) ^ $past(pol))))
        else $error("normalised controls lag wrong"); // R2

endmodule

// File: rtl/vts_shadow.sv
module vts_shadow #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [HW-1:0] in_hsa,
    input  logic [HW-1:0] in_hbp,
    input  logic [HW-1:0] in_hact,
    input  logic [HW-1:0] in_hline,
    input  logic [VW-1:0] in_vsa,
    input  logic [VW-1:0] in_vbp,
    input  logic [VW-1:0] in_vact,
    input  logic [VW-1:0] in_vfp,
    input  logic [1:0]    in_mode,
    input  logic [5:0]    in_lpen,
    output logic [HW-1:0] sh_hsa,
    output logic [HW-1:0] sh_hbp,
    output logic [HW-1:0] sh_hact,
    output logic [HW-1:0] sh_hline,
    output logic [VW-1:0] sh_vsa,
    output logic [VW-1:0] sh_vbp,
    output logic [VW-1:0] sh_vact,
    output logic [VW-1:0] sh_vfp,
    output logic [1:0]    sh_mode,
    output logic [5:0]    sh_lpen
);

    typedef struct packed {
        logic [HW-1:0] hsa;
        logic [HW-1:0] hbp;
        logic [HW-1:0] hact;
        logic [HW-1:0] hline;
        logic [VW-1:0] vsa;
        logic [VW-1:0] vbp;
        logic [VW-1:0] vact;
        logic [VW-1:0] vfp;
        logic [1:0]    mode;
        logic [5:0]    lpen;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.hsa   = in_hsa;
            c_d.hbp   = in_hbp;
            c_d.hact  = in_hact;
            c_d.hline = in_hline;
            c_d.vsa   = in_vsa;
            c_d.vbp   = in_vbp;
            c_d.vact  = in_vact;
            c_d.vfp   = in_vfp;
            c_d.mode  = in_mode;
            c_d.lpen  = in_lpen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sh_hsa   = c_q.hsa;
    assign sh_hbp   = c_q.hbp;
    assign sh_hact  = c_q.hact;
    assign sh_hline = c_q.hline;
    assign sh_vsa   = c_q.vsa;
    assign sh_vbp   = c_q.vbp;
    assign sh_vact  = c_q.vact;
    assign sh_vfp   = c_q.vfp;
    assign sh_mode  = c_q.mode;
    assign sh_lpen  = c_q.lpen;

endmodule

// File: rtl/vts_line_ctr.sv
module vts_line_ctr
    import vts_pkg::*;
#(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [HW-1:0] hsa,
    input  logic [HW-1:0] hbp,
    input  logic [HW-1:0] hact,
    input  logic [HW-1:0] hline,
    output logic [HW+1:0] hpos,
    output phase_e        hphase,
    output logic          line_end
);

    localparam int HCW = HW + 2;

    typedef struct packed {
        logic [HCW-1:0] cnt;
    } line_st_t;

    line_st_t s_d, s_q;
    logic [HCW-1:0] e_sync, e_back, e_actv, len, last;

    always_comb begin
        e_sync = HCW'(hsa);
        e_back = e_sync + HCW'(hbp);
        e_actv = e_back + HCW'(hact);
        len    = (HCW'(hline) > e_actv) ? HCW'(hline) : e_actv;
        if (len == '0) len = HCW'(1);
        last     = len - HCW'(1);
        line_end = run && (s_q.cnt == last);

        s_d = s_q;
        if (start)    s_d.cnt = '0;
        else if (run) s_d.cnt = line_end ? '0 : s_q.cnt + HCW'(1);
        else          s_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hpos   = s_q.cnt;
    assign hphase = seg_of(32'(s_q.cnt), 32'(e_sync), 32'(e_back), 32'(e_actv));

    AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_end) |=> (s_q.cnt == $past(s_q.cnt) + HCW'(1)))
        else $error("line position skipped"); // R4
    AST_HPOS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.cnt < len))
        else $error("line position past line length"); // R5
    AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (s_q.cnt == '0))
        else $error("line position not home while idle"); // R7

endmodule

// File: rtl/vts_frame_ctr.sv
module vts_frame_ctr
    import vts_pkg::*;
#(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          line_end,
    input  logic [VW-1:0] vsa,
    input  logic [VW-1:0] vbp,
    input  logic [VW-1:0] vact,
    input  logic [VW-1:0] vfp,
    output logic          run,
    output logic [VW+1:0] vline,
    output phase_e        vphase
);

    localparam int VCW = VW + 2;

    typedef struct packed {
        logic           run;
        logic [VCW-1:0] cnt;
    } frame_st_t;

    frame_st_t s_d, s_q;
    logic [VCW-1:0] e_sync, e_back, e_actv, tot, last;

    always_comb begin
        e_sync = VCW'(vsa);
        e_back = e_sync + VCW'(vbp);
        e_actv = e_back + VCW'(vact);
        tot    = e_actv + VCW'(vfp);
        if (tot == '0) tot = VCW'(1);
        last = tot - VCW'(1);

        s_d = s_q;
        if (start) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
        end else if (line_end) begin
            if (s_q.cnt == last) begin
                s_d.run = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + VCW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run    = s_q.run;
    assign vline  = s_q.cnt;
    assign vphase = seg_of(32'(s_q.cnt), 32'(e_sync), 32'(e_back), 32'(e_actv));

    AST_VLINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !line_end) |=> $stable(s_q.cnt))
        else $error("line index moved mid-line"); // R6
    AST_VLINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.cnt < tot))
        else $error("line index past frame"); // R6

endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
    import vts_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW-1:0]    cfg_hsa,
    input  logic [HW-1:0]    cfg_hbp,
    input  logic [HW-1:0]    cfg_hact,
    input  logic [HW-1:0]    cfg_hline,
    input  logic [VW-1:0]    cfg_vsa,
    input  logic [VW-1:0]    cfg_vbp,
    input  logic [VW-1:0]    cfg_vact,
    input  logic [VW-1:0]    cfg_vfp,
    input  logic [1:0]       cfg_mode,
    input  logic [5:0]       cfg_lpen,
    input  logic [CTL_W-1:0] cfg_pol,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [CTL_W-1:0] ctl_norm,
    output logic             busy,
    output logic             frame_start,
    output logic [HW+1:0]    hpos,
    output logic [1:0]       hphase,
    output logic [VW+1:0]    vline,
    output logic [1:0]       vphase,
    output logic             lp_ok
);

    logic          start, line_end;
    logic [HW-1:0] sh_hsa, sh_hbp, sh_hact, sh_hline;
    logic [VW-1:0] sh_vsa, sh_vbp, sh_vact, sh_vfp;
    logic [1:0]    sh_mode;
    logic [5:0]    sh_lpen;
    phase_e        ph_h, ph_v, ph_h_eff;
    vmode_e        mode;

    vts_pol_sync u_pol (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .pol(cfg_pol),
        .run(busy), .ctl_norm(ctl_norm), .start(start)
    );

    vts_shadow #(.HW(HW), .VW(VW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(start),
        .in_hsa(cfg_hsa), .in_hbp(cfg_hbp), .in_hact(cfg_hact), .in_hline(cfg_hline),
        .in_vsa(cfg_vsa), .in_vbp(cfg_vbp), .in_vact(cfg_vact), .in_vfp(cfg_vfp),
        .in_mode(cfg_mode), .in_lpen(cfg_lpen),
        .sh_hsa(sh_hsa), .sh_hbp(sh_hbp), .sh_hact(sh_hact), .sh_hline(sh_hline),
        .sh_vsa(sh_vsa), .sh_vbp(sh_vbp), .sh_vact(sh_vact), .sh_vfp(sh_vfp),
        .sh_mode(sh_mode), .sh_lpen(sh_lpen)
    );

    vts_line_ctr #(.HW(HW)) u_line (
        .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
        .hsa(sh_hsa), .hbp(sh_hbp), .hact(sh_hact), .hline(sh_hline),
        .hpos(hpos), .hphase(ph_h), .line_end(line_end)
    );

    vts_frame_ctr #(.VW(VW)) u_frame (
        .clk(clk), .rst_n(rst_n), .start(start), .line_end(line_end),
        .vsa(sh_vsa), .vbp(sh_vbp), .vact(sh_vact), .vfp(sh_vfp),
        .run(busy), .vline(vline), .vphase(ph_v)
    );

    assign mode        = vmode_e'(sh_mode);
    assign hphase      = busy ? ph_h : PH_SYNC;
    assign vphase      = busy ? ph_v : PH_SYNC;
    assign frame_start = busy && (hpos == '0) && (vline == '0);

    always_comb begin
        ph_h_eff = (ph_h == PH_SYNC) ? PH_BACK : ph_h;
        lp_ok    = 1'b0;
        if (!busy) begin
            lp_ok = 1'b1;
        end else if ((ph_h == PH_SYNC) && ((mode == VM_PULSE) || (mode == VM_RSVD))) begin
            lp_ok = 1'b0;
        end else if (ph_v != PH_ACTV) begin
            case (ph_v)
                PH_SYNC: lp_ok = sh_lpen[LPB_VSYNC];
                PH_BACK: lp_ok = sh_lpen[LPB_VBACK];
                default: lp_ok = sh_lpen[LPB_VFRNT];
            endcase
        end else begin
            case (ph_h_eff)
                PH_BACK:  lp_ok = sh_lpen[LPB_HBACK];
                PH_FRONT: lp_ok = (mode == VM_BURST) ? sh_lpen[LPB_VACTV] : sh_lpen[LPB_HFRNT];
                default:  lp_ok = 1'b0;
            endcase
        end
    end

    AST_START_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_norm[CTL_VS]))
        else $error("frame began without sync edge"); // R3
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            $stable({sh_hsa, sh_hbp, sh_hact, sh_hline, sh_vsa, sh_vbp, sh_vact, sh_vfp, sh_mode, sh_lpen}))
        else $error("settings changed inside a frame"); // R9
    AST_NO_LP_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (hphase == 2'd2) && (vphase == 2'd2)) |-> !lp_ok)
        else $error("low power during payload"); // R10

endmodule

// File: tb/vid_timing_seq_test.sv
`timescale 1ns/100ps
module vid_timing_seq_test;

    localparam int HW = 6;
    localparam int VW = 5;
    localparam int NV = 6;

    typedef struct packed {
        logic [HW-1:0] hsa;
        logic [HW-1:0] hbp;
        logic [HW-1:0] hact;
        logic [HW-1:0] hline;
        logic [VW-1:0] vsa;
        logic [VW-1:0] vbp;
        logic [VW-1:0] vact;
        logic [VW-1:0] vfp;
        logic [1:0]    mode;
        logic [5:0]    en;
        logic [4:0]    pol;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{6'd2,  6'd3,  6'd6,  6'd16, 5'd1, 5'd2, 5'd3, 5'd2, 2'd0, 6'b111111, 5'b00000},
        '{6'd1,  6'd1,  6'd4,  6'd5,  5'd2, 5'd1, 5'd2, 5'd1, 2'd1, 6'b010101, 5'b00010},
        '{6'd3,  6'd0,  6'd5,  6'd12, 5'd1, 5'd0, 5'd4, 5'd0, 2'd2, 6'b001000, 5'b11111},
        '{6'd0,  6'd2,  6'd3,  6'd9,  5'd0, 5'd1, 5'd2, 5'd3, 2'd2, 6'b100000, 5'b00000},
        '{6'd0,  6'd0,  6'd0,  6'd0,  5'd0, 5'd0, 5'd0, 5'd0, 2'd0, 6'b000000, 5'b00100},
        '{6'd40, 6'd30, 6'd20, 6'd63, 5'd0, 5'd0, 5'd1, 5'd0, 2'd3, 6'b111111, 5'b00010}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HW-1:0] cfg_hsa, cfg_hbp, cfg_hact, cfg_hline;
    logic [VW-1:0] cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp;
    logic [1:0]    cfg_mode;
    logic [5:0]    cfg_lpen;
    logic [4:0]    cfg_pol, ctl_in, ctl_norm;
    logic          busy, frame_start, lp_ok;
    logic [HW+1:0] hpos;
    logic [1:0]    hphase, vphase;
    logic [VW+1:0] vline;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    vid_timing_seq #(.HW(HW), .VW(VW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hline(cfg_hline),
        .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .cfg_mode(cfg_mode), .cfg_lpen(cfg_lpen), .cfg_pol(cfg_pol), .ctl_in(ctl_in),
        .ctl_norm(ctl_norm), .busy(busy), .frame_start(frame_start),
        .hpos(hpos), .hphase(hphase), .vline(vline), .vphase(vphase), .lp_ok(lp_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic apply_cfg(input vec_t v);
        cfg_hsa = v.hsa; cfg_hbp = v.hbp; cfg_hact = v.hact; cfg_hline = v.hline;
        cfg_vsa = v.vsa; cfg_vbp = v.vbp; cfg_vact = v.vact; cfg_vfp = v.vfp;
        cfg_mode = v.mode; cfg_lpen = v.en;
    endtask

    function automatic int seg(input int p, input int a, input int b, input int c);
        if (p < a) return 0;
        if (p < b) return 1;
        if (p < c) return 2;
        return 3;
    endfunction

    // low-power permission as stated in R10
    function automatic int exp_lp(input int hp, input int vp, input int md, input logic [5:0] en);
        int eh;
        eh = hp;
        if (hp == 0) begin
            if (md == 0 || md == 3) return 0;
            eh = 1;
        end
        if (vp != 2) return int'(en[(vp == 3) ? 2 : vp]);
        if (eh == 1) return int'(en[4]);
        if (eh == 2) return 0;
        return (md == 2) ? int'(en[3]) : int'(en[5]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t cv;
        int L, V, tot, m, c, sh, sv;
        cfg_pol = '0;
        ctl_in  = '0;
        apply_cfg(VT[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 hpos", int'(hpos), 0);
        chk("R1 vline", int'(vline), 0);
        chk("R1 hphase", int'(hphase), 0);
        chk("R1 vphase", int'(vphase), 0);
        chk("R1 ctl_norm", int'(ctl_norm), 0);
        chk("R1 lp_ok", int'(lp_ok), 1);

        for (int i = 0; i < NV; i++) begin
            cv = VT[i];
            apply_cfg(cv);
            cfg_pol = cv.pol;
            ctl_in  = cv.pol ^ 5'b00010;
            repeat (2) @(negedge clk);
            sh = int'(cv.hsa) + int'(cv.hbp) + int'(cv.hact);
            L  = (int'(cv.hline) > sh) ? int'(cv.hline) : sh;
            if (L == 0) L = 1;
            sv = int'(cv.vsa) + int'(cv.vbp) + int'(cv.vact) + int'(cv.vfp);
            V  = (sv == 0) ? 1 : sv;
            tot = L * V;
            m   = tot / 2;
            c   = 0;
            for (int v = 0; v < V; v++) begin
                for (int h = 0; h < L; h++) begin
                    int ehp, evp;
                    ehp = seg(h, int'(cv.hsa), int'(cv.hsa) + int'(cv.hbp), sh);
                    evp = seg(v, int'(cv.vsa), int'(cv.vsa) + int'(cv.vbp),
                              int'(cv.vsa) + int'(cv.vbp) + int'(cv.vact));
                    chk("R3 busy", int'(busy), 1);
                    chk("R3 frame_start", int'(frame_start), (h == 0 && v == 0) ? 1 : 0);
                    chk("R5 hpos", int'(hpos), h);
                    chk("R4 hphase", int'(hphase), ehp);
                    chk("R6 vline", int'(vline), v);
                    chk("R6 vphase", int'(vphase), evp);
                    chk("R10 lp_ok", int'(lp_ok), exp_lp(ehp, evp, int'(cv.mode), cv.en));
                    if (tot >= 4 && c == m + 3) chk("R8 busy kept", int'(busy), 1);
                    if (i < NV - 1 && c == tot - 1) chk("R9 old line length", int'(hpos), L - 1);
                    if (c == 0) ctl_in = cv.pol;
                    if (tot >= 4 && c == m) begin
                        ctl_in = cv.pol ^ 5'b00010;
                        if (i < NV - 1) apply_cfg(VT[i+1]);
                    end
                    if (tot >= 4 && c == m + 1) ctl_in = cv.pol;
                    c++;
                    @(negedge clk);
                end
            end
            chk("R7 busy end", int'(busy), 0);
            chk("R7 hpos end", int'(hpos), 0);
            chk("R7 vline end", int'(vline), 0);
            chk("R10 lp idle", int'(lp_ok), 1);
            repeat (3) @(negedge clk);
            chk("R7 stays idle", int'(busy), 0);
        end

        // R2 polarity normalisation, one register stage
        cfg_pol = 5'b01101;
        ctl_in  = 5'b10100;
        @(negedge clk);
        chk("R2 ctl_norm a", int'(ctl_norm), 5'b11001);
        ctl_in = 5'b00001;
        @(negedge clk);
        chk("R2 ctl_norm b", int'(ctl_norm), 5'b01100);
        chk("R2 no frame", int'(busy), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule